// File: doc/BRIEF.md
# Paired-Register GPIO Access Controller

This block is the register file and command-pointer logic of a 16-pin general-purpose I/O expander. It sits behind a serial-bus slave byte engine that has already done the bit-level framing and address matching. The engine hands it one-cycle events: a start condition, an address match carrying the read/write bit, a received byte, a request for the next byte to transmit, and the master's acknowledge or not-acknowledge after each transmitted byte.

Eight 8-bit registers are organised as four pairs: sampled inputs, output values, read polarity and pin direction. A write transfer carries a command byte and then data bytes. A read transfer, usually after a repeated start, streams bytes from the register the last command selected. The pointer does not count upward. After every data byte it flips to the other register of the same pair, so a transfer of any length alternates between port 0 and port 1 of one register kind.

The block never stalls its source. Every event is taken in the cycle it is presented, so the byte interfaces carry a valid strobe and no ready. `tx_data` holds its value between requests.

Top module: `gpio_pair_regs`

## Requirements
- R1: After reset the output registers read 0xFF, the polarity registers 0x00 and the direction registers 0xFF. All `pin_oe` bits are 0, all `pin_out` bits are 1, and the pointer selects command 0.
- R2: The first received byte after a write-address event is the command. Its bits [2:0] select 0 input port 0, 1 input port 1, 2 output port 0, 3 output port 1, 4 polarity port 0, 5 polarity port 1, 6 direction port 0, 7 direction port 1. Bits above bit 2 are ignored.
- R3: Each further received byte in a write transfer is stored in the selected register. The pointer then flips bit 0, staying inside the pair, for any number of bytes.
- R4: Bytes written to command 0 or 1 are discarded and change no other register. The pointer still alternates.
- R5: Port 0 maps to pins [7:0] and port 1 to pins [15:8]. A direction bit of 1 makes the pin an input (`pin_oe`=0). A bit of 0 drives it (`pin_oe`=1). `pin_out` always carries the output register bit.
- R6: Reading command 0 or 1 returns the synchronised pin level XOR the matching polarity bit, whatever the pin direction. A pin change becomes visible three clock edges later (two synchronizer flops and one input register).
- R7: Reading command 2 or 3 returns the stored output register, not the pin level.
- R8: In a read transfer, `tx_req` loads `tx_data` on the next edge from the register under the pointer, and `tx_data` changes at no other time. Each master acknowledge event flips pointer bit 0. After a not-acknowledge, further acknowledge events are ignored until the next start or address event.
- R9: The pointer is kept across transfers. A read address with no new command reads from where the previous transfer left the pointer.
- R10: Received bytes during a read transfer, or before any address event, change no register and no pointer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_addr | input | 1 | Own address matched this cycle |
| addr_rw | input | 1 | Read/write bit with `ev_addr`, 1 = read |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | PORT_W | Received byte |
| tx_req | input | 1 | Engine asks for the next byte to send |
| tx_data | output | PORT_W | Byte to send, loaded on `tx_req` |
| ack_valid | input | 1 | Master acknowledge slot after a sent byte |
| ack_nack | input | 1 | With `ack_valid`: 1 = not-acknowledge |
| pin_in | input | 2*PORT_W | Pin levels, asynchronous |
| pin_out | output | 2*PORT_W | Output register values |
| pin_oe | output | 2*PORT_W | Per-pin driver enable |

## Verification
A wrong pointer appears at once as data in the wrong register. A write that lands in the partner port shows on `pin_out` or `pin_oe` at the next clock edge. A read that returns the partner byte shows on `tx_data` one edge after `tx_req`. A corrupted phase state shows as a command byte stored as data, or as bytes accepted during a read. A stale or mis-polarised input path shows only when an input register is read, three edges or more after the pin moves, so the bench waits past that window before reading.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  // Transfer phase of the command pointer
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_WR,
    PH_RD,
    PH_RD_END
  } phase_t;

  localparam int SEL_W = 3;

  // Register kind: pointer bits [2:1]; port: pointer bit 0
  localparam logic [1:0] KIND_IN  = 2'd0;
  localparam logic [1:0] KIND_OUT = 2'd1;
  localparam logic [1:0] KIND_POL = 2'd2;
  localparam logic [1:0] KIND_CFG = 2'd3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmd_pointer.sv
module cmd_pointer
  import gpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_addr,
  input  logic             addr_rw,
  input  logic             rx_valid,
  input  logic [SEL_W-1:0] cmd_bits,
  input  logic             ack_valid,
  input  logic             ack_nack,
  output logic [SEL_W-1:0] ptr,
  output logic             wr_en
);
  phase_t           phase_q;
  logic [SEL_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
    end else if (ev_start) begin
      phase_q <= PH_IDLE;
    end else if (ev_addr) begin
      phase_q <= addr_rw ? PH_RD : PH_CMD;
    end else begin
      case (phase_q)
        PH_CMD: if (rx_valid) begin
          ptr_q   <= cmd_bits;
          phase_q <= PH_WR;
        end
        PH_WR: if (rx_valid) ptr_q[0] <= ~ptr_q[0];
        PH_RD: if (ack_valid) begin
          ptr_q[0] <= ~ptr_q[0];
          if (ack_nack) phase_q <= PH_RD_END;
        end
        default: ;
      endcase
    end
  end

  assign ptr   = ptr_q;
  assign wr_en = rx_valid && !ev_start && !ev_addr && (phase_q == PH_WR);

  // R3
  pair_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WR && rx_valid && !ev_start && !ev_addr) |=>
      (ptr_q[2:1] == $past(ptr_q[2:1])) && (ptr_q[0] != $past(ptr_q[0])));

  // R8
  read_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RD_END && !ev_start && !ev_addr) |=> $stable(ptr_q));

  // R9
  ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !ack_valid) |=> $stable(ptr_q));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import gpx_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PW-1:0]    wr_data,
  input  logic [2*PW-1:0]  pins_synced,
  output logic [2*PW-1:0]  in_q,
  output logic [2*PW-1:0]  out_q,
  output logic [2*PW-1:0]  pol_q,
  output logic [2*PW-1:0]  cfg_q
);
  localparam int NPORT = 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= pins_synced;
  end

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic hit;
      assign hit = wr_en && (wr_sel[0] == 1'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_q[p*PW +: PW] <= '1;
          pol_q[p*PW +: PW] <= '0;
          cfg_q[p*PW +: PW] <= '1;
        end else if (hit) begin
          case (wr_sel[2:1])
            KIND_OUT: out_q[p*PW +: PW] <= wr_data;
            KIND_POL: pol_q[p*PW +: PW] <= wr_data;
            KIND_CFG: cfg_q[p*PW +: PW] <= wr_data;
            default:  ;
          endcase
        end
      end
    end
  endgenerate

  // R4
  input_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[2:1] == KIND_IN) |=>
      ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

  // R3
  port0_write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2) |=> (out_q[2*PW-1:PW] == $past(out_q[2*PW-1:PW])));
endmodule

// File: rtl/gpio_pair_regs.sv
module gpio_pair_regs
  import gpx_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_start,
  input  logic                ev_addr,
  input  logic                addr_rw,
  input  logic                rx_valid,
  input  logic [PORT_W-1:0]   rx_data,
  input  logic                tx_req,
  output logic [PORT_W-1:0]   tx_data,
  input  logic                ack_valid,
  input  logic                ack_nack,
  input  logic [2*PORT_W-1:0] pin_in,
  output logic [2*PORT_W-1:0] pin_out,
  output logic [2*PORT_W-1:0] pin_oe
);
  localparam int PINS = 2 * PORT_W;

  logic [SEL_W-1:0] ptr;
  logic             wr_en;
  logic [PINS-1:0]  pins_synced, in_q, out_q, pol_q, cfg_q;
  logic [PINS-1:0]  in_view;
  logic [PINS-1:0]  kind_word;
  logic [PORT_W-1:0] rd_byte;

  pin_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pins_synced)
  );

  cmd_pointer u_ptr (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_addr(ev_addr),
    .addr_rw(addr_rw), .rx_valid(rx_valid), .cmd_bits(rx_data[SEL_W-1:0]),
    .ack_valid(ack_valid), .ack_nack(ack_nack), .ptr(ptr), .wr_en(wr_en)
  );

  reg_bank #(.PW(PORT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(ptr), .wr_data(rx_data),
    .pins_synced(pins_synced), .in_q(in_q), .out_q(out_q), .pol_q(pol_q),
    .cfg_q(cfg_q)
  );

  assign in_view = in_q ^ pol_q;

  always_comb begin
    case (ptr[2:1])
      KIND_IN:  kind_word = in_view;
      KIND_OUT: kind_word = out_q;
      KIND_POL: kind_word = pol_q;
      default:  kind_word = cfg_q;
    endcase
    rd_byte = ptr[0] ? kind_word[PINS-1:PORT_W] : kind_word[PORT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_data <= '0;
    else if (tx_req) tx_data <= rd_byte;
  end

  assign pin_out = out_q;
  assign pin_oe  = ~cfg_q;

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> $stable(tx_data));

  // R5
  oe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(pin_oe) && $stable(pin_out));
endmodule

// File: tb/sim_gpio_pair_regs.sv
module sim_gpio_pair_regs;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int PINS = 2 * PW;
  localparam int NVEC = 5;

  // {cmd, d0, d1, expected pin_out, expected pin_oe}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'h02, 8'hA5, 8'h3C, 16'h3CA5, 16'h0000},
    {8'h07, 8'h0F, 8'hF0, 16'h3CA5, 16'hF00F},
    {8'hF3, 8'h11, 8'h22, 16'h1122, 16'hF00F},
    {8'h00, 8'h77, 8'h88, 16'h1122, 16'hF00F},
    {8'h86, 8'h00, 8'h00, 16'h1122, 16'hFFFF}
  };

  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_addr = 0, addr_rw = 0, rx_valid = 0;
  logic tx_req = 0, ack_valid = 0, ack_nack = 0;
  logic [PW-1:0] rx_data = '0, tx_data;
  logic [PINS-1:0] pin_in = 16'h5A96, pin_out, pin_oe;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  gpio_pair_regs #(.PORT_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_addr(ev_addr),
    .addr_rw(addr_rw), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_data(tx_data), .ack_valid(ack_valid),
    .ack_nack(ack_nack), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_start();
    ev_start = 1; @(negedge clk); ev_start = 0;
  endtask
  task automatic do_addr(input logic rw);
    ev_addr = 1; addr_rw = rw; @(negedge clk); ev_addr = 0; addr_rw = 0;
  endtask
  task automatic do_rx(input logic [7:0] d);
    rx_valid = 1; rx_data = d; @(negedge clk); rx_valid = 0; rx_data = '0;
  endtask
  task automatic do_tx();
    tx_req = 1; @(negedge clk); tx_req = 0;
  endtask
  task automatic do_ack(input logic nack);
    ack_valid = 1; ack_nack = nack; @(negedge clk); ack_valid = 0; ack_nack = 0;
  endtask
  task automatic wr_xfer(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
    do_start(); do_addr(1'b0); do_rx(c); do_rx(a); do_rx(b);
  endtask
  task automatic rd_begin(input logic [7:0] c);
    do_start(); do_addr(1'b0); do_rx(c); do_start(); do_addr(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", pin_out, 16'hFFFF);
    chk("R1 pin_oe", pin_oe, 16'h0000);
    do_start(); do_addr(1'b1); do_tx();
    chk("R1 default pointer reads input 0", {8'h00, tx_data}, 16'h0096);
    rd_begin(8'h04); do_tx();
    chk("R1 polarity default", {8'h00, tx_data}, 16'h0000);
    rd_begin(8'h07); do_tx();
    chk("R1 direction default", {8'h00, tx_data}, 16'h00FF);

    // R10: byte before any address event
    do_start(); do_rx(8'h02); do_rx(8'h00);
    chk("R10 pre-address byte", pin_out, 16'hFFFF);

    // Vector table: R2/R3/R5 (entry 3 has upper command bits, entry 4 is R4)
    for (int i = 0; i < NVEC; i++) begin
      wr_xfer(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32]);
      chk($sformatf("R2/R3/R5 vector %0d pin_out", i), pin_out, VEC[i][31:16]);
      chk($sformatf("R4/R5 vector %0d pin_oe", i), pin_oe, VEC[i][15:0]);
    end

    // R3: long write alternates inside the output pair
    do_start(); do_addr(1'b0); do_rx(8'h02);
    do_rx(8'h01); do_rx(8'h02); do_rx(8'h03); do_rx(8'h04);
    chk("R3 long write", pin_out, 16'h0403);

    // R6/R8: input read with polarity, alternating, NACK end
    wr_xfer(8'h04, 8'hFF, 8'h00);
    rd_begin(8'h00);
    do_tx(); chk("R6 input0 inverted", {8'h00, tx_data}, 16'h0069);
    do_ack(1'b0);
    do_tx(); chk("R8 alternate to input1", {8'h00, tx_data}, 16'h005A);
    do_ack(1'b0);
    do_tx(); chk("R8 back to input0", {8'h00, tx_data}, 16'h0069);
    do_ack(1'b1);
    do_ack(1'b0);
    do_tx(); chk("R8 ack after nack ignored", {8'h00, tx_data}, 16'h005A);

    // R9: new read without command keeps pointer
    do_start(); do_addr(1'b1);
    do_tx(); chk("R9 pointer kept", {8'h00, tx_data}, 16'h005A);

    // R10: received byte during read ignored
    do_rx(8'h06);
    do_tx(); chk("R10 rx in read, pointer", {8'h00, tx_data}, 16'h005A);
    chk("R10 rx in read, pins", pin_out, 16'h0403);

    // R7: output register, not pin level
    rd_begin(8'h02); do_tx();
    chk("R7 output readback", {8'h00, tx_data}, 16'h0003);

    // R6: pins driven as outputs still sampled, after sync latency
    pin_in = 16'hC3E1;
    repeat (4) @(negedge clk);
    rd_begin(8'h01);
    do_tx(); chk("R6 input1 new level", {8'h00, tx_data}, 16'h00C3);
    do_ack(1'b0);
    do_tx(); chk("R6 input0 new level inverted", {8'h00, tx_data}, 16'h001E);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule